// File: doc/BRIEF.md
# Inverting Write Encoder with Flag

This block is the write path in front of a small array of non-volatile storage words. It exists to cut the number of cells that get programmed on each store. A write is never sent straight to the array. The block first fetches the word that is physically held at the target entry, together with that entry's one-bit inversion flag. It then counts how many data bits differ between the new value and the held pattern. If more than half of the bits would change, it stores the complement of the new value and sets the flag. Last, it drives a per-bit enable mask so that only cells whose level actually flips are programmed; the flag cell is treated the same way.

Reads pass through an asynchronous port. It returns the held pattern XORed with the entry's flag copied across the whole width, so the caller always sees the logical value it last wrote. The array is modelled as plain registers. Each write takes a fixed three-cycle sequence (fetch, decide, masked store), and `busy` is high for the whole sequence. A count of the cells programmed by the most recent write is presented for test benches.

Top module: `flip_write_encoder`

## Requirements
- R1: After reset every entry reads back as zero with its flag clear, `busy` is 0, `wrDone` is 0 and `progCount` is 0.
- R2: A write request sampled while idle raises `busy` on the next cycle. `busy` stays high for exactly three cycles. `wrDone` pulses for one cycle in the first cycle after `busy` falls, and the new data is readable from that same cycle.
- R3: A write request sampled while `busy` is high is ignored. The entry it names keeps its previous contents, and no further busy sequence follows.
- R4: When the number of differing data bits between the new value and the held pattern exceeds DATA_W/2, the complement is held and the flag is set to 1. Otherwise the true value is held and the flag is 0.
- R5: When exactly DATA_W/2 data bits differ, the true value is held and the flag is 0.
- R6: Only cells whose level changes are programmed. `progCount` equals the number of differing data bits between the old and new held patterns, plus 1 if the flag changed.
- R7: `rdData` equals the held pattern of entry `rdAddr` XORed with its flag copied across all DATA_W bits. That is the last value written to that entry, or zero if the entry was never written.
- R8: No write programs more than DATA_W/2 + 1 cells.
- R9: `progCount` changes only in the cycle in which `wrDone` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrReq | input | 1 | Write request, taken only while idle |
| wrAddr | input | ADDR_W | Target entry of the write |
| wrData | input | DATA_W | Logical value to store |
| rdAddr | input | ADDR_W | Entry to read |
| rdData | output | DATA_W | Logical (decoded) value of entry rdAddr |
| busy | output | 1 | High while a write sequence is running |
| wrDone | output | 1 | One-cycle pulse when a write has committed |
| progCount | output | CNT_W | Number of cells programmed by the last write |

## Verification
A wrong inversion decision leaves the logical value correct but changes the number of programmed cells. That error therefore shows up only on `progCount`, in the `wrDone` cycle of the faulty write, or on a later write to the same entry, where the held pattern and flag differ from the model. A flag or mask error that corrupts the stored pattern shows on `rdData` from the cycle after commit, for any read of that entry. A sequencer fault shows at once in the length of the `busy` window or in a missing or misplaced `wrDone` pulse.

// File: rtl/fwe_pkg.sv
package fwe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DECIDE = 2'd2,
    ST_STORE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic accept;   // latch address and data of a new write
    logic capOld;   // capture held pattern and flag of the target
    logic decide;   // compute inversion choice and cell mask
    logic commit;   // apply the masked store
  } wrStrobe_t;

endpackage

// File: rtl/fwe_ctrl.sv
module fwe_ctrl
  import fwe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrReq,
  output wrStrobe_t  strobe,
  output logic       busy,
  output logic       wrDone
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (wrReq) stateNext = ST_FETCH;
      ST_FETCH:  stateNext = ST_DECIDE;
      ST_DECIDE: stateNext = ST_STORE;
      ST_STORE:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrDone <= 1'b0;
    end else begin
      state  <= stateNext;
      wrDone <= (state == ST_STORE);
    end
  end

  always_comb begin
    strobe.accept = (state == ST_IDLE) && wrReq;
    strobe.capOld = (state == ST_FETCH);
    strobe.decide = (state == ST_DECIDE);
    strobe.commit = (state == ST_STORE);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fwe_datapath.sv
module fwe_datapath
  import fwe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  progCount
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] cellWord [DEPTH];
  logic              cellFlag [DEPTH];

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] oldWord;
  logic              oldFlag;
  logic [DATA_W-1:0] newWord;
  logic              newFlag;
  logic [DATA_W-1:0] maskWord;
  logic              maskFlag;

  // inversion decision against the physically held bits
  int                diffCount;
  logic              invertSel;
  logic [DATA_W-1:0] candWord;

  always_comb begin
    diffCount = $countones(dataQ ^ oldWord);
    invertSel = (diffCount > HALF);
    candWord  = dataQ ^ {DATA_W{invertSel}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      dataQ     <= '0;
      oldWord   <= '0;
      oldFlag   <= 1'b0;
      newWord   <= '0;
      newFlag   <= 1'b0;
      maskWord  <= '0;
      maskFlag  <= 1'b0;
      progCount <= '0;
    end else begin
      if (strobe.accept) begin
        addrQ <= wrAddr;
        dataQ <= wrData;
      end
      if (strobe.capOld) begin
        oldWord <= cellWord[addrQ];
        oldFlag <= cellFlag[addrQ];
      end
      if (strobe.decide) begin
        newWord  <= candWord;
        newFlag  <= invertSel;
        maskWord <= candWord ^ oldWord;
        maskFlag <= invertSel ^ oldFlag;
      end
      if (strobe.commit) begin
        progCount <= CNT_W'($countones({maskFlag, maskWord}));
      end
    end
  end

  // per-entry storage with per-cell write enables
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = strobe.commit && (addrQ == ADDR_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cellWord[e] <= '0;
        cellFlag[e] <= 1'b0;
      end else if (hit) begin
        for (int b = 0; b < DATA_W; b++) begin
          if (maskWord[b]) cellWord[e][b] <= newWord[b];
        end
        if (maskFlag) cellFlag[e] <= newFlag;
      end
    end
  end

  assign rdData = cellWord[rdAddr] ^ {DATA_W{cellFlag[rdAddr]}};

endmodule

// File: rtl/flip_write_encoder.sv
module flip_write_encoder
  import fwe_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DATA_W + 2)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              wrDone,
  output logic [CNT_W-1:0]  progCount
);

  wrStrobe_t strobe;

  fwe_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrReq  (wrReq),
    .strobe (strobe),
    .busy   (busy),
    .wrDone (wrDone)
  );

  fwe_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .progCount (progCount)
  );

endmodule

// File: rtl/fwe_checker.sv
module fwe_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              wrDone,
  input logic [CNT_W-1:0]  progCount,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);

  localparam int LIMIT = DATA_W / 2 + 1;

  assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> (!busy && $past(busy)));

  assert_prog_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> (int'(progCount) <= LIMIT));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrDone |-> $stable(progCount));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrDone && $stable(rdAddr)) |-> $stable(rdData));

endmodule

bind flip_write_encoder fwe_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_fwe_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .wrDone    (wrDone),
  .progCount (progCount),
  .rdAddr    (rdAddr),
  .rdData    (rdData)
);

// File: tb/flip_write_encoder_bench.sv
module flip_write_encoder_bench;

  localparam int W  = 8;
  localparam int D  = 4;
  localparam int AW = 2;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrReq;
  logic [AW-1:0] wrAddr;
  logic [W-1:0]  wrData;
  logic [AW-1:0] rdAddr;
  logic [W-1:0]  rdData;
  logic          busy;
  logic          wrDone;
  logic [CW-1:0] progCount;

  int vectors  = 0;
  int failures = 0;

  // model of physical contents
  logic [W-1:0] mWord [D];
  logic         mFlag [D];
  logic [W-1:0] mLogic [D];

  always #10 clk = ~clk;

  flip_write_encoder #(.DATA_W(W), .DEPTH(D)) u_flip_write_encoder (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .wrDone(wrDone),
    .progCount(progCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
  endtask

  // read every entry through the port and compare to the model
  task automatic readAll(input string tag);
    for (int a = 0; a < D; a++) begin
      rdAddr = AW'(a);
      #1;
      check(rdData == mLogic[a], tag, int'(rdData), int'(mLogic[a]));
    end
  endtask

  // one write; expCnt >= 0 overrides the model's cell count (hand-worked cases)
  task automatic doWrite(input int a, input logic [W-1:0] d, input bit intrude,
                         input int expCnt);
    int           hd;
    bit           inv;
    logic [W-1:0] npw;
    int           cnt;
    hd  = $countones(d ^ mWord[a]);
    inv = (hd > W / 2);
    npw = inv ? ~d : d;
    cnt = $countones(npw ^ mWord[a]) + ((inv != mFlag[a]) ? 1 : 0);
    if (expCnt >= 0) cnt = expCnt;

    @(negedge clk);
    wrReq  = 1'b1;
    wrAddr = AW'(a);
    wrData = d;
    @(negedge clk);
    wrReq = 1'b0;
    check(busy == 1'b1, "R2 busy cycle 1", int'(busy), 1);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy cycle 2", int'(busy), 1);
    if (intrude) begin
      wrReq  = 1'b1;
      wrAddr = AW'((a + 1) % D);
      wrData = ~mLogic[(a + 1) % D];
    end
    @(negedge clk);
    wrReq = 1'b0;
    check(busy == 1'b1, "R2 busy cycle 3", int'(busy), 1);
    check(wrDone == 1'b0, "R2 no early done", int'(wrDone), 0);
    @(negedge clk);
    check(busy == 1'b0, "R2 busy falls", int'(busy), 0);
    check(wrDone == 1'b1, "R2 done pulse", int'(wrDone), 1);
    check(int'(progCount) == cnt, "R6 programmed cells", int'(progCount), cnt);
    check(int'(progCount) <= W / 2 + 1, "R8 bound", int'(progCount), W / 2 + 1);

    mWord[a]  = npw;
    mFlag[a]  = inv;
    mLogic[a] = d;
    rdAddr = AW'(a);
    #1;
    check(rdData == d, "R7 readback", int'(rdData), int'(d));

    @(negedge clk);
    check(wrDone == 1'b0, "R2 done one cycle", int'(wrDone), 0);
    check(int'(progCount) == cnt, "R9 count holds", int'(progCount), cnt);
    if (intrude) begin
      check(busy == 1'b0, "R3 no second sequence", int'(busy), 0);
      readAll("R3 intruding write ignored");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int a = 0; a < D; a++) begin
      mWord[a] = '0; mFlag[a] = 1'b0; mLogic[a] = '0;
    end
    rstN = 1'b0; wrReq = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(wrDone == 1'b0, "R1 done", int'(wrDone), 0);
    check(progCount == '0, "R1 count", int'(progCount), 0);
    readAll("R1 reset contents");

    // R5 tie: held 0x00, write 0x0F -> 4 of 8 differ, stays true, 4 cells
    doWrite(0, 8'h0F, 1'b0, 4);
    // R4 invert: held 0x0F, write 0xF8 -> 7 differ, holds 0x07 flag 1: 1 data + flag = 2
    doWrite(0, 8'hF8, 1'b0, 2);
    // R4 back: held 0x07 flag1, write 0x07 -> 0 differ, true, flag clears: 1 cell
    doWrite(0, 8'h07, 1'b0, 1);
    // R4 full flip: held 0x00, write 0xFF -> complement 0x00, only flag: 1 cell
    doWrite(1, 8'hFF, 1'b0, 1);
    // R6 no change: same value again programs nothing
    doWrite(1, 8'hFF, 1'b0, 0);
    // R3 request while busy
    doWrite(2, 8'hA5, 1'b1, -1);
    doWrite(3, 8'h3C, 1'b1, -1);

    // near-exhaustive sweep: every data value against varied held patterns
    for (int n = 0; n < 1024; n++) begin
      doWrite(n % D, W'((n * 29 + n / 7) ^ (n >> 3)), (n % 97) == 0, -1);
      if ((n % 64) == 0) readAll("R7 sweep contents");
    end
    // every value over the tie boundary for one entry
    for (int v = 0; v < 256; v++) begin
      doWrite(2, W'(v), 1'b0, -1);
    end
    readAll("R7 final contents");

    summary();
    $finish;
  end

endmodule